// File: doc/BRIEF.md
# Synchronous Serial Channel with Block-Transfer Buffer

This block is one channel of a clocked serial link with an eight-slot, byte-wide buffer. Software fills the slots it wants to send and programs how many bytes to move (one to eight). A single start pulse then shifts the whole block out, most significant bit first, with no software action between bytes. Every byte clocked in from the line is written back over the byte that was just sent from the same slot. When the last byte is done, a one-cycle completion pulse is raised and the received block can be read from the slots.

The serial clock either comes from the block itself (controller role), with a half period set in system-clock cycles, or from the pin (follower role), in which case it passes through a synchronizer first. Received data is sampled on the rising serial clock edge, and transmit data is updated on the falling edge. An optional select-gated mode ties the channel to an active-low select input. While select is high, the clock and data outputs are released and shifting is held off. If select rises while a block is in progress, the block is abandoned and an error flag is set.

Top module: `sio_autoxfer`

## Requirements
- R1: After reset, `busy`, `done_irq` and `xfer_err` are 0, `sck_o` and `sdo` are 1, and all buffer slots read 0.
- R2: While idle, a write with `host_we` stores `host_wdata` in slot `host_idx`, and `host_rdata` always shows slot `host_idx`. While `busy` is 1, host writes are ignored.
- R3: A start sends `xfer_len`+1 bytes (`xfer_len`=0 means 1 byte, 7 means 8), taken from slot 0 upward. Each byte goes MSB first. `sdo` takes the next bit in the system cycle where the serial clock falls.
- R4: `sdi` is sampled when the serial clock rises. The eight bits received for byte k (first bit most significant) replace slot k. Slots at or above `xfer_len`+1 are left unchanged.
- R5: In the controller role (`master`=1), `sck_o` idles high. While shifting it has a half period of `div_half`+1 system cycles. `sck_oe` is 1 when select gating is off.
- R6: In the follower role (`master`=0), the edges of `sck_i` after synchronization time the transfer, and `sck_oe` is 0.
- R7: `busy` rises in the cycle after an accepted start and stays high until the last byte completes.
- R8: `done_irq` is high for exactly one cycle per completed block, in the same cycle that `busy` falls.
- R9: With `cs_mode`=1, while the synchronized `cs_n` is high, `sck_oe` and `sdo_oe` are 0 and no bit is shifted. Once `cs_n` is low, both outputs are driven and shifting runs.
- R10: With `cs_mode`=1, a rise of `cs_n` while `busy` is 1 clears `busy`, sets `xfer_err`, and gives no `done_irq`. The next accepted start clears `xfer_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Buffer slot write strobe |
| host_idx | input | 3 | Slot index for write and read |
| host_wdata | input | 8 | Slot write data |
| host_rdata | output | 8 | Contents of slot `host_idx` |
| xfer_len | input | 3 | Byte count minus one |
| start | input | 1 | Start pulse for a block transfer |
| master | input | 1 | 1: internal serial clock, 0: clock from pin |
| cs_mode | input | 1 | Enables select-gated operation |
| div_half | input | 4 | Serial clock half period minus one, in system cycles |
| busy | output | 1 | Transfer in progress |
| done_irq | output | 1 | One-cycle completion pulse |
| xfer_err | output | 1 | Block abandoned by select rising |
| cs_n | input | 1 | Active-low select |
| sck_i | input | 1 | Serial clock from pin |
| sck_o | output | 1 | Generated serial clock |
| sck_oe | output | 1 | Drive enable for the serial clock pin |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Drive enable for the data-out pin |

## Verification
The bench uses the default build: 8-bit bytes, eight slots, a 4-bit divider and a two-stage synchronizer. Because the buffer has only eight slots, the controller-role sweep can cover every byte count from 1 to 8 with half periods of 1, 2 and 4 cycles, and check every transmitted and received bit against patterns computed in the bench. The same small configuration also makes the follower role, select gating, a mid-block abort and writes attempted during a transfer cheap to exercise at the pins.

// File: rtl/sio_pkg.sv
package sio_pkg;

   typedef struct packed {
      logic rise;
      logic fall;
   } sck_evt_t;

   function automatic int unsigned idx_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/sio_sync.sv
module sio_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("sio_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/sio_fifo.sv
module sio_fifo #(
   parameter  int DATA_W = 8,
   parameter  int DEPTH  = 8,
   localparam int IDX_W  = sio_pkg::idx_width(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_we,
   input  logic              host_block,
   input  logic [IDX_W-1:0]  host_idx,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   input  logic              eng_we,
   input  logic [IDX_W-1:0]  eng_widx,
   input  logic [DATA_W-1:0] eng_wdata,
   input  logic [IDX_W-1:0]  eng_ridx,
   output logic [DATA_W-1:0] eng_rdata
);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("sio_fifo: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [DEPTH-1:0][DATA_W-1:0] mem;
   logic [DEPTH-1:0][DATA_W-1:0] mem_nx;

   // Engine writes win; host writes only land while the channel is idle.
   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_slot
         always_comb begin
            mem_nx[g] = mem[g];
            if (eng_we && eng_widx == IDX_W'(g))
               mem_nx[g] = eng_wdata;
            else if (host_we && !host_block && host_idx == IDX_W'(g))
               mem_nx[g] = host_wdata;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem <= '0;
      else        mem <= mem_nx;
   end

   assign host_rdata = mem[host_idx];
   assign eng_rdata  = mem[eng_ridx];

   // R2: host cannot change any slot during a transfer
   a_r2_frozen_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (host_block && !eng_we) |=> $stable(mem));

endmodule

// File: rtl/sio_sckgen.sv
module sio_sckgen import sio_pkg::*; #(
   parameter int DIV_W       = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             master,
   input  logic             run,
   input  logic [DIV_W-1:0] div_half,
   input  logic             sck_pin,
   output logic             sck_q,
   output sck_evt_t         evt
);

   logic [DIV_W-1:0] cnt;
   logic             tick;
   logic             pin_s;
   logic             pin_p;

   // Controller role: divider toggles sck_q every div_half+1 cycles.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         sck_q <= 1'b1;
      end else if (!run || !master) begin
         cnt   <= '0;
         sck_q <= 1'b1;
      end else if (cnt == div_half) begin
         cnt   <= '0;
         sck_q <= ~sck_q;
      end else begin
         cnt   <= cnt + 1'b1;
      end
   end

   assign tick = master && run && (cnt == div_half);

   // Follower role: synchronized pin clock with edge detect.
   sio_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pin_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (sck_pin),
      .q     (pin_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_p <= 1'b1;
      else        pin_p <= pin_s;
   end

   always_comb begin
      if (master) begin
         evt.rise = tick && !sck_q;
         evt.fall = tick &&  sck_q;
      end else begin
         evt.rise = run &&  pin_s && !pin_p;
         evt.fall = run && !pin_s &&  pin_p;
      end
   end

endmodule

// File: rtl/sio_engine.sv
module sio_engine import sio_pkg::*; #(
   parameter  int DATA_W = 8,
   parameter  int DEPTH  = 8,
   localparam int IDX_W  = idx_width(DEPTH),
   localparam int BIT_W  = idx_width(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [IDX_W-1:0]  len,
   input  logic              cs_mode,
   input  logic              cs_s,
   input  sck_evt_t          evt,
   input  logic              sdi,
   input  logic [DATA_W-1:0] rd_data,
   output logic [IDX_W-1:0]  rd_idx,
   output logic              wr_en,
   output logic [IDX_W-1:0]  wr_idx,
   output logic [DATA_W-1:0] wr_data,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic              run,
   output logic              sdo
);

   generate
      if (DATA_W < 4) begin : g_bad_width
         $error("sio_engine: DATA_W must be at least 4");
      end
   endgenerate

   localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(DATA_W - 1);

   logic [IDX_W-1:0]  len_q;
   logic [IDX_W-1:0]  byte_idx;
   logic [BIT_W-1:0]  bitcnt;
   logic [DATA_W-1:0] tx;
   logic [DATA_W-2:0] rx;
   logic              cs_p;
   logic              abort;
   logic              byte_end;

   assign run      = busy && (!cs_mode || !cs_s);
   assign abort    = busy && cs_mode && cs_s && !cs_p;
   assign byte_end = busy && !abort && evt.rise && (bitcnt == BIT_LAST);

   assign rd_idx   = busy ? byte_idx + 1'b1 : '0;
   assign wr_en    = byte_end;
   assign wr_idx   = byte_idx;
   assign wr_data  = {rx, sdi};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         done     <= 1'b0;
         err      <= 1'b0;
         len_q    <= '0;
         byte_idx <= '0;
         bitcnt   <= '0;
         tx       <= '0;
         rx       <= '0;
         sdo      <= 1'b1;
         cs_p     <= 1'b1;
      end else begin
         done <= 1'b0;
         cs_p <= cs_s;
         if (abort) begin
            busy <= 1'b0;
            err  <= 1'b1;
         end else if (!busy) begin
            if (start) begin
               busy     <= 1'b1;
               err      <= 1'b0;
               len_q    <= len;
               byte_idx <= '0;
               bitcnt   <= '0;
               tx       <= rd_data;
            end
         end else begin
            if (evt.fall) begin
               sdo <= tx[DATA_W-1];
               tx  <= {tx[DATA_W-2:0], 1'b0};
            end
            if (evt.rise) begin
               rx     <= {rx[DATA_W-3:0], sdi};
               bitcnt <= bitcnt + 1'b1;
               if (bitcnt == BIT_LAST) begin
                  bitcnt   <= '0;
                  byte_idx <= byte_idx + 1'b1;
                  tx       <= rd_data;
                  if (byte_idx == len_q) begin
                     busy <= 1'b0;
                     done <= 1'b1;
                  end
               end
            end
         end
      end
   end

   // R3: byte pointer never passes the programmed count
   a_r3_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (byte_idx <= len_q));

   // R8: completion is a single-cycle pulse
   a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8: completion coincides with busy dropping
   a_r8_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $fell(busy));

   // R10: error rises only with an abandoned block, never with completion
   a_r10_err_on_abort: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> ($fell(busy) && !done));

endmodule

// File: rtl/sio_autoxfer.sv
module sio_autoxfer import sio_pkg::*; #(
   parameter  int DATA_W      = 8,
   parameter  int DEPTH       = 8,
   parameter  int DIV_W       = 4,
   parameter  int SYNC_STAGES = 2,
   localparam int IDX_W       = idx_width(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_we,
   input  logic [IDX_W-1:0]  host_idx,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   input  logic [IDX_W-1:0]  xfer_len,
   input  logic              start,
   input  logic              master,
   input  logic              cs_mode,
   input  logic [DIV_W-1:0]  div_half,
   output logic              busy,
   output logic              done_irq,
   output logic              xfer_err,
   input  logic              cs_n,
   input  logic              sck_i,
   output logic              sck_o,
   output logic              sck_oe,
   input  logic              sdi,
   output logic              sdo,
   output logic              sdo_oe
);

   generate
      if (DIV_W < 1) begin : g_bad_div
         $error("sio_autoxfer: DIV_W must be at least 1");
      end
   endgenerate

   logic              cs_s;
   logic              run;
   sck_evt_t          evt;
   logic [IDX_W-1:0]  rd_idx;
   logic [DATA_W-1:0] rd_data;
   logic              wr_en;
   logic [IDX_W-1:0]  wr_idx;
   logic [DATA_W-1:0] wr_data;
   logic              drive_en;

   sio_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (cs_n),
      .q     (cs_s)
   );

   sio_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_we    (host_we),
      .host_block (busy),
      .host_idx   (host_idx),
      .host_wdata (host_wdata),
      .host_rdata (host_rdata),
      .eng_we     (wr_en),
      .eng_widx   (wr_idx),
      .eng_wdata  (wr_data),
      .eng_ridx   (rd_idx),
      .eng_rdata  (rd_data)
   );

   sio_sckgen #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_sckgen (
      .clk      (clk),
      .rst_n    (rst_n),
      .master   (master),
      .run      (run),
      .div_half (div_half),
      .sck_pin  (sck_i),
      .sck_q    (sck_o),
      .evt      (evt)
   );

   sio_engine #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_engine (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .len      (xfer_len),
      .cs_mode  (cs_mode),
      .cs_s     (cs_s),
      .evt      (evt),
      .sdi      (sdi),
      .rd_data  (rd_data),
      .rd_idx   (rd_idx),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .wr_data  (wr_data),
      .busy     (busy),
      .done     (done_irq),
      .err      (xfer_err),
      .run      (run),
      .sdo      (sdo)
   );

   assign drive_en = !cs_mode || !cs_s;
   assign sck_oe   = master && drive_en;
   assign sdo_oe   = drive_en;

   // R5: generated clock sits high whenever no transfer is running
   a_r5_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !$past(busy)) |-> sck_o);

   // R9: no bit is written back while select holds the channel off
   a_r9_no_write_gated: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_mode && cs_s && $past(cs_s)) |-> !wr_en);

endmodule

// File: tb/sio_autoxfer_bench.sv
module sio_autoxfer_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       host_we = 1'b0;
   logic [2:0] host_idx = '0;
   logic [7:0] host_wdata = '0;
   logic [7:0] host_rdata;
   logic [2:0] xfer_len = '0;
   logic       start = 1'b0;
   logic       master = 1'b1;
   logic       cs_mode = 1'b0;
   logic [3:0] div_half = '0;
   logic       busy, done_irq, xfer_err;
   logic       cs_n = 1'b1;
   logic       sck_i = 1'b1;
   logic       sck_o, sck_oe, sdo, sdo_oe;
   logic       m_sdi = 1'b0;
   logic       s_sdi = 1'b0;
   logic       sdi;

   assign sdi = master ? m_sdi : s_sdi;

   sio_autoxfer u_sio_autoxfer (
      .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_idx(host_idx),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .xfer_len(xfer_len),
      .start(start), .master(master), .cs_mode(cs_mode), .div_half(div_half),
      .busy(busy), .done_irq(done_irq), .xfer_err(xfer_err), .cs_n(cs_n),
      .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe), .sdi(sdi), .sdo(sdo),
      .sdo_oe(sdo_oe)
   );

   always #10 clk = ~clk;

   int nchk = 0;
   int nerr = 0;
   int cyc = 0;
   int done_cnt = 0;

   always @(posedge clk) begin
      cyc++;
      if (done_irq) done_cnt++;
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Pin-level model of the far end in the controller role.
   logic [7:0] plan_rx [8];
   logic [7:0] cap_tx  [8];
   int  m_bit = 0;
   bit  m_act = 1'b0;
   int  f0 = 0;
   int  f1 = 0;

   always @(negedge sck_o) begin
      if (m_act && master && m_bit < 64) begin
         if (m_bit == 0) f0 = cyc;
         if (m_bit == 1) f1 = cyc;
         m_sdi = plan_rx[m_bit / 8][7 - (m_bit % 8)];
      end
   end

   always @(posedge sck_o) begin
      if (m_act && master && m_bit < 64) begin
         cap_tx[m_bit / 8][7 - (m_bit % 8)] = sdo;
         m_bit++;
      end
   end

   function automatic logic [7:0] pat(input int i, input int s);
      return 8'((i * 41) + (s * 19) + 5);
   endfunction

   function automatic logic [7:0] resp(input int i, input int s);
      return pat(i, s) ^ 8'hA5 ^ 8'(i);
   endfunction

   task automatic wr(input int i, input logic [7:0] v);
      host_idx = 3'(i); host_wdata = v; host_we = 1'b1;
      @(negedge clk);
      host_we = 1'b0;
   endtask

   task automatic rd(input int i, output logic [7:0] v);
      host_idx = 3'(i);
      #1;
      v = host_rdata;
   endtask

   task automatic pulse_start(input int len);
      xfer_len = 3'(len); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_idle();
      for (int t = 0; t < 20000 && busy; t++) @(negedge clk);
      @(negedge clk); @(negedge clk);
   endtask

   task automatic run_master(input int len, input int div, input int seed);
      logic [7:0] v;
      int d0;
      master = 1'b1; cs_mode = 1'b0; div_half = 4'(div);
      for (int i = 0; i < 8; i++) begin
         wr(i, pat(i, seed));
         plan_rx[i] = resp(i, seed);
         cap_tx[i]  = 8'h00;
      end
      m_bit = 0; m_act = 1'b1; d0 = done_cnt;
      pulse_start(len);
      chk(busy == 1'b1, "R7 busy after start", busy, 1);
      chk(sck_oe == 1'b1, "R5 sck_oe in controller role", sck_oe, 1);
      wait_idle();
      m_act = 1'b0;
      chk(m_bit == (len + 1) * 8, "R3 bit count", m_bit, (len + 1) * 8);
      for (int i = 0; i <= len; i++)
         chk(cap_tx[i] == pat(i, seed), "R3 transmitted byte", cap_tx[i], pat(i, seed));
      chk(f1 - f0 == 2 * (div + 1), "R5 clock period", f1 - f0, 2 * (div + 1));
      chk(sck_o == 1'b1, "R5 clock idles high", sck_o, 1);
      chk(done_cnt - d0 == 1, "R8 one-cycle done pulse", done_cnt - d0, 1);
      for (int i = 0; i < 8; i++) begin
         rd(i, v);
         if (i <= len) chk(v == resp(i, seed), "R4 received byte in slot", v, resp(i, seed));
         else          chk(v == pat(i, seed), "R4 slot beyond count unchanged", v, pat(i, seed));
      end
   endtask

   task automatic run_slave(input int len, input int seed);
      logic [7:0] v;
      logic [7:0] got;
      int d0;
      master = 1'b0; cs_mode = 1'b0; sck_i = 1'b1;
      for (int i = 0; i < 8; i++) wr(i, pat(i, seed));
      d0 = done_cnt;
      pulse_start(len);
      chk(sck_oe == 1'b0, "R6 sck_oe low in follower role", sck_oe, 0);
      for (int b = 0; b <= len; b++) begin
         got = 8'h00;
         for (int k = 7; k >= 0; k--) begin
            sck_i = 1'b0;
            s_sdi = resp(b, seed) >> k;
            repeat (6) @(negedge clk);
            got[k] = sdo;
            sck_i = 1'b1;
            repeat (6) @(negedge clk);
         end
         chk(got == pat(b, seed), "R6 follower transmitted byte", got, pat(b, seed));
      end
      wait_idle();
      chk(busy == 1'b0, "R7 busy clear after follower block", busy, 0);
      chk(done_cnt - d0 == 1, "R8 follower done pulse", done_cnt - d0, 1);
      for (int i = 0; i <= len; i++) begin
         rd(i, v);
         chk(v == resp(i, seed), "R6 follower received byte", v, resp(i, seed));
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      nerr++; nchk++;
      $display("FAIL R7 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

   initial begin
      logic [7:0] v;
      int d0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(busy == 1'b0, "R1 busy", busy, 0);
      chk(done_irq == 1'b0, "R1 done_irq", done_irq, 0);
      chk(xfer_err == 1'b0, "R1 xfer_err", xfer_err, 0);
      chk(sck_o == 1'b1, "R1 sck_o", sck_o, 1);
      chk(sdo == 1'b1, "R1 sdo", sdo, 1);
      for (int i = 0; i < 8; i++) begin
         rd(i, v);
         chk(v == 8'h00, "R1 slot cleared", v, 0);
      end

      // R2 idle write and readback
      wr(5, 8'h6E);
      rd(5, v);
      chk(v == 8'h6E, "R2 idle write readback", v, 8'h6E);

      // R3 R4 R5 R8 sweep over count and divider
      for (int len = 0; len < 8; len++)
         for (int di = 0; di < 3; di++)
            run_master(len, (1 << di) - 1, len * 3 + di);

      // R2 host write while busy is ignored
      master = 1'b1; div_half = 4'd0;
      wr(7, 8'hC3);
      pulse_start(1);
      host_idx = 3'd7; host_wdata = 8'h11; host_we = 1'b1;
      @(negedge clk);
      host_we = 1'b0;
      wait_idle();
      rd(7, v);
      chk(v == 8'hC3, "R2 write during busy ignored", v, 8'hC3);

      // R6 follower role
      run_slave(0, 40);
      run_slave(2, 41);

      // R9 select-gated transfer
      master = 1'b1; cs_mode = 1'b1; cs_n = 1'b1; div_half = 4'd1;
      repeat (4) @(negedge clk);
      for (int i = 0; i < 3; i++) begin
         wr(i, pat(i, 50));
         plan_rx[i] = resp(i, 50);
      end
      m_bit = 0; m_act = 1'b1; d0 = done_cnt;
      pulse_start(2);
      repeat (20) @(negedge clk);
      chk(busy == 1'b1, "R9 busy while select high", busy, 1);
      chk(sck_oe == 1'b0, "R9 sck_oe released", sck_oe, 0);
      chk(sdo_oe == 1'b0, "R9 sdo_oe released", sdo_oe, 0);
      chk(m_bit == 0, "R9 no shifting while select high", m_bit, 0);
      cs_n = 1'b0;
      repeat (4) @(negedge clk);
      chk(sck_oe == 1'b1, "R9 sck_oe driven", sck_oe, 1);
      chk(sdo_oe == 1'b1, "R9 sdo_oe driven", sdo_oe, 1);
      wait_idle();
      m_act = 1'b0;
      chk(m_bit == 24, "R9 gated block bit count", m_bit, 24);
      chk(cap_tx[2] == pat(2, 50), "R9 gated block last byte", cap_tx[2], pat(2, 50));
      chk(done_cnt - d0 == 1, "R9 gated block done", done_cnt - d0, 1);

      // R10 abort by select rising mid-block
      cs_n = 1'b1;
      repeat (4) @(negedge clk);
      d0 = done_cnt;
      m_bit = 0; m_act = 1'b1;
      pulse_start(7);
      cs_n = 1'b0;
      repeat (40) @(negedge clk);
      chk(busy == 1'b1, "R10 busy before abort", busy, 1);
      cs_n = 1'b1;
      repeat (6) @(negedge clk);
      m_act = 1'b0;
      chk(busy == 1'b0, "R10 busy cleared by abort", busy, 0);
      chk(xfer_err == 1'b1, "R10 error set", xfer_err, 1);
      chk(done_cnt == d0, "R10 no done on abort", done_cnt - d0, 0);
      chk(sck_oe == 1'b0, "R9 outputs released after abort", sck_oe, 0);

      // R10 next start clears the error
      cs_mode = 1'b0; m_bit = 0; m_act = 1'b1;
      pulse_start(0);
      chk(xfer_err == 1'b0, "R10 error cleared by start", xfer_err, 0);
      wait_idle();
      m_act = 1'b0;
      chk(m_bit == 8, "R3 single byte after abort", m_bit, 8);

      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

endmodule